// File: doc/BRIEF.md
# Lookup-Unit Control Register File

This block is the bus-side register file that configures the packet lookup engine of an Ethernet switch. It holds one global control word and a bank of per-port settings. The global word carries a master enable, a trigger that starts a flush of the pending-update queue into the hash table, and the choice of hash polynomial. The trigger bit reads back as a busy flag until the flush logic returns a one-cycle done pulse.

Per-port settings are not mapped one register per port. A port-select register names one port, and a single window register shows and updates that port's settings. The lookup engine can also load a port's settings from its own side. All settings leave the block on a flat bus, forced to zero while the master enable is off.

The bus is a simple single-beat slave. A word index picks the register, and an acknowledge follows every access after exactly one cycle.

Top module: `lkc_regs`

## Requirements
- R1: After reset the enable is 0, busy is 0, the polynomial is 0x1021, the selected port is 0 and every port's settings are 0.
- R2: Word 0 bit 0 is the master enable. While it is 0, `port_cfg_o` is all zeros. While it is 1, each port's byte of `port_cfg_o` equals that port's stored settings.
- R3: Writing word 0 with bit 1 set while idle gives a one-cycle `flush_start_o` pulse in the cycle after the access. From then on, `flush_busy_o` and word 0 bit 1 read 1. Writing bit 1 as 0 starts nothing.
- R4: Busy returns to 0 on the clock edge that samples `flush_done_i` high. A trigger written while busy gives no start pulse.
- R5: The polynomial lives in word 0 bits 23:8. Only 0x1021, 0x8005 and 0x0589 are accepted. Any other written value leaves the stored polynomial unchanged.
- R6: Word 1 bits 7:0 hold the read/write selected port. Word 1 bits 15:8 read the number of ports, and writes to those bits are ignored.
- R7: Word 2 is the window for the selected port. Its fields are: bit 0 learning, bit 1 pass-all, bit 2 pass-BPDU, bit 3 fixed priority, bits 6:4 priority, bit 7 drop unrecognised multicast. Bits 31:8 read 0. A window write changes only the selected port.
- R8: With a selected port at or beyond the port count, word 2 reads 0 and writes to it change no port.
- R9: An engine-side load (`eng_load_i`, `eng_port_i`, `eng_cfg_i`) replaces that port's settings. The new value is visible on the outputs one edge later.
- R10: If a bus window write and an engine load target the same port on the same edge, the bus value is kept. If they target different ports, both take effect.
- R11: `bus_ack_o` rises one edge after `bus_cyc_i` is raised and lasts one cycle. `bus_rdata_o` returns the register's value from before that access's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cyc_i | input | 1 | Access request |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 2 | Word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with ack |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| flush_done_i | input | 1 | Flush logic finished |
| flush_start_o | output | 1 | One-cycle flush request |
| flush_busy_o | output | 1 | Flush in progress |
| glb_en_o | output | 1 | Master enable |
| poly_o | output | 16 | Selected hash polynomial |
| eng_load_i | input | 1 | Engine-side settings load |
| eng_port_i | input | 8 | Port for the engine load |
| eng_cfg_i | input | 8 | Settings for the engine load |
| port_cfg_o | output | NPORTS*8 | Effective settings, byte p for port p |

## Verification
Every register result is due one edge after the access edge. The bench drives each access at a falling edge and reads the acknowledge and read data at the next falling edge. The start pulse and the busy flag appear on the same edge as the acknowledge of the triggering write, so they are sampled at that same falling edge. Busy clears on the edge that samples the done pulse, and engine loads show one edge after they are driven. Each of these is read at the falling edge that follows, and collision cases drive both sources in the same half-cycle so that they meet at one edge.

// File: rtl/lkc_pkg.sv
package lkc_pkg;

   typedef enum logic [1:0] {
      W_GLOBAL = 2'd0,
      W_PSEL   = 2'd1,
      W_PORT   = 2'd2,
      W_SPARE  = 2'd3
   } word_e;

   typedef struct packed {
      logic       drop_umc;
      logic [2:0] prio;
      logic       fix_prio;
      logic       pass_bpdu;
      logic       pass_all;
      logic       learn;
   } port_cfg_t;

   localparam int CFG_W = $bits(port_cfg_t);

   function automatic logic poly_ok(input logic [15:0] v);
      return (v == 16'h1021) || (v == 16'h8005) || (v == 16'h0589);
   endfunction

endpackage

// File: rtl/lkc_global.sv
module lkc_global
   import lkc_pkg::*;
#(
   parameter logic [15:0] POLY_RST = 16'h1021,
   parameter int          DW       = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic          flush_done,
   output logic          en_o,
   output logic [15:0]   poly_o,
   output logic          busy_o,
   output logic          start_o
);

   localparam int POLY_LSB = 8;

   if (!poly_ok(POLY_RST)) begin : g_bad_poly
      $error("lkc_global: POLY_RST is not a supported polynomial");
   end
   if (DW < POLY_LSB + 16) begin : g_bad_dw
      $error("lkc_global: DW too narrow for the polynomial field");
   end

   logic        en_q, busy_q, start_q;
   logic [15:0] poly_q;
   logic [15:0] poly_w;
   logic        trig;

   assign poly_w = wdata[POLY_LSB +: 16];
   assign trig   = wr_en && wdata[1] && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         poly_q  <= POLY_RST;
      end else begin
         start_q <= trig;
         if (flush_done) busy_q <= 1'b0;
         if (trig)       busy_q <= 1'b1;
         if (wr_en) begin
            en_q <= wdata[0];
            if (poly_ok(poly_w)) poly_q <= poly_w;
         end
      end
   end

   assign en_o    = en_q;
   assign poly_o  = poly_q;
   assign busy_o  = busy_q;
   assign start_o = start_q;

   // R3: start is a single-cycle pulse and comes with busy
   p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);
   p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> busy_q);
   // R4: busy only falls after a done pulse, only rises with a start
   p_busy_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(flush_done));
   p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> start_q);
   // R5: stored polynomial is always a supported one
   p_poly_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      poly_ok(poly_q));

endmodule

// File: rtl/lkc_port_bank.sv
module lkc_port_bank
   import lkc_pkg::*;
#(
   parameter int NPORTS = 10,
   parameter int SEL_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel_wr,
   input  logic [SEL_W-1:0]        sel_wdata,
   input  logic                    win_wr,
   input  port_cfg_t               win_wdata,
   input  logic                    eng_load,
   input  logic [SEL_W-1:0]        eng_port,
   input  port_cfg_t               eng_cfg,
   output logic [SEL_W-1:0]        sel_o,
   output port_cfg_t               win_o,
   output logic [NPORTS*CFG_W-1:0] cfg_flat_o
);

   localparam logic [SEL_W-1:0] NP = SEL_W'(NPORTS);

   if (NPORTS < 1 || NPORTS >= (1 << SEL_W)) begin : g_bad_np
      $error("lkc_port_bank: NPORTS out of range for SEL_W");
   end

   logic [SEL_W-1:0] sel_q;
   logic             sel_valid;
   port_cfg_t        cfg_q [NPORTS];
   port_cfg_t        win_mux;

   assign sel_valid = sel_q < NP;

   always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_wr) sel_q <= sel_wdata;
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic bus_hit, eng_hit;
      assign bus_hit = win_wr && sel_valid && (sel_q == SEL_W'(p));
      assign eng_hit = eng_load && (eng_port == SEL_W'(p));

      always_ff @(posedge clk) begin
         if (!rst_n)       cfg_q[p] <= '0;
         else if (bus_hit) cfg_q[p] <= win_wdata;
         else if (eng_hit) cfg_q[p] <= eng_cfg;
      end

      assign cfg_flat_o[p*CFG_W +: CFG_W] = cfg_q[p];

      // R10: bus wins over a same-port engine load
      p_bus_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_hit && eng_hit) |=> (cfg_q[p] == $past(win_wdata)));
      // R9: a lone engine load lands
      p_eng_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (eng_hit && !bus_hit) |=> (cfg_q[p] == $past(eng_cfg)));
   end

   always_comb begin
      win_mux = '0;
      for (int p = 0; p < NPORTS; p++)
         if (sel_q == SEL_W'(p)) win_mux = cfg_q[p];
   end

   assign sel_o = sel_q;
   assign win_o = win_mux;

   // R8: the window reads zero for an unbuilt port
   p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |-> (win_mux == '0));

endmodule

// File: rtl/lkc_regs.sv
module lkc_regs
   import lkc_pkg::*;
#(
   parameter int          NPORTS   = 10,
   parameter int          SEL_W    = 8,
   parameter int          DW       = 32,
   parameter logic [15:0] POLY_RST = 16'h1021
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_cyc_i,
   input  logic                      bus_we_i,
   input  logic [1:0]                bus_addr_i,
   input  logic [DW-1:0]             bus_wdata_i,
   output logic [DW-1:0]             bus_rdata_o,
   output logic                      bus_ack_o,
   input  logic                      flush_done_i,
   output logic                      flush_start_o,
   output logic                      flush_busy_o,
   output logic                      glb_en_o,
   output logic [15:0]               poly_o,
   input  logic                      eng_load_i,
   input  logic [SEL_W-1:0]          eng_port_i,
   input  logic [CFG_W-1:0]          eng_cfg_i,
   output logic [NPORTS*CFG_W-1:0]   port_cfg_o
);

   if (DW < 2 * SEL_W) begin : g_bad_dw
      $error("lkc_regs: DW too narrow for the port-select word");
   end

   logic                    ack_q;
   logic [DW-1:0]           rdata_q;
   logic                    acc, wr;
   word_e                   word;
   logic                    en, busy;
   logic [15:0]             poly;
   logic [SEL_W-1:0]        sel;
   port_cfg_t               win;
   logic [NPORTS*CFG_W-1:0] cfg_flat;
   logic [DW-1:0]           rd_mux;

   assign acc  = bus_cyc_i && !ack_q;
   assign wr   = acc && bus_we_i;
   assign word = word_e'(bus_addr_i);

   lkc_global #(.POLY_RST(POLY_RST), .DW(DW)) u_glob (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr && word == W_GLOBAL),
      .wdata      (bus_wdata_i),
      .flush_done (flush_done_i),
      .en_o       (en),
      .poly_o     (poly),
      .busy_o     (busy),
      .start_o    (flush_start_o)
   );

   lkc_port_bank #(.NPORTS(NPORTS), .SEL_W(SEL_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_wr     (wr && word == W_PSEL),
      .sel_wdata  (bus_wdata_i[SEL_W-1:0]),
      .win_wr     (wr && word == W_PORT),
      .win_wdata  (port_cfg_t'(bus_wdata_i[CFG_W-1:0])),
      .eng_load   (eng_load_i),
      .eng_port   (eng_port_i),
      .eng_cfg    (port_cfg_t'(eng_cfg_i)),
      .sel_o      (sel),
      .win_o      (win),
      .cfg_flat_o (cfg_flat)
   );

   always_comb begin
      rd_mux = '0;
      case (word)
         W_GLOBAL: begin
            rd_mux[0]     = en;
            rd_mux[1]     = busy;
            rd_mux[23:8]  = poly;
         end
         W_PSEL: begin
            rd_mux[SEL_W-1:0]       = sel;
            rd_mux[2*SEL_W-1:SEL_W] = SEL_W'(NPORTS);
         end
         W_PORT:  rd_mux[CFG_W-1:0] = win;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q <= acc;
         if (acc) rdata_q <= rd_mux;
      end
   end

   assign bus_ack_o    = ack_q;
   assign bus_rdata_o  = rdata_q;
   assign flush_busy_o = busy;
   assign glb_en_o     = en;
   assign poly_o       = poly;
   assign port_cfg_o   = en ? cfg_flat : '0;

   // R11: acknowledge is a one-cycle pulse that follows a request
   p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |=> !ack_q);
   p_ack_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> $past(bus_cyc_i));
   // R2: nothing leaves while disabled
   p_off_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (port_cfg_o == '0));

endmodule

// File: tb/sim_lkc_regs.sv
module sim_lkc_regs;
   localparam int NP = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cyc = 1'b0, we = 1'b0;
   logic [1:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          ack;
   logic          done = 1'b0;
   logic          start, busy, en;
   logic [15:0]   poly;
   logic          eld = 1'b0;
   logic [7:0]    eport = '0, ecfg = '0;
   logic [NP*8-1:0] pcfg;

   int total = 0, bad = 0;

   always #5 clk = ~clk;

   lkc_regs #(.NPORTS(NP)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_cyc_i(cyc), .bus_we_i(we),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .bus_ack_o(ack), .flush_done_i(done), .flush_start_o(start),
      .flush_busy_o(busy), .glb_en_o(en), .poly_o(poly),
      .eng_load_i(eld), .eng_port_i(eport), .eng_cfg_i(ecfg),
      .port_cfg_o(pcfg));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // one access; leaves the clock at the falling edge after the ack
   task automatic acc(input logic w, input logic [1:0] a, input logic [31:0] d,
                      output logic [31:0] q);
      @(negedge clk);
      cyc = 1'b1; we = w; addr = a; wdata = d;
      @(negedge clk);
      q = rdata;
      cyc = 1'b0; we = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      logic [31:0] q;
      acc(1'b1, a, d, q);
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] q);
      acc(1'b0, a, 32'h0, q);
   endtask

   task automatic t_reset;
      logic [31:0] q;
      rd(2'd0, q); chk("R1 global", q, 32'h0010_2100);
      rd(2'd1, q); chk("R1 psel", q, 32'h0000_0A00);
      chk("R1 cfg out", 32'(pcfg == '0), 32'd1);
      chk("R1 busy", 32'(busy), 32'd0);
   endtask

   task automatic t_ack;
      @(negedge clk);
      cyc = 1'b1; we = 1'b0; addr = 2'd0;
      chk("R11 ack before edge", 32'(ack), 32'd0);
      @(negedge clk);
      chk("R11 ack after one edge", 32'(ack), 32'd1);
      cyc = 1'b0;
      @(negedge clk);
      chk("R11 ack one cycle", 32'(ack), 32'd0);
   endtask

   task automatic t_window;
      logic [31:0] q;
      wr(2'd1, 32'h0000_FF03);
      rd(2'd1, q); chk("R6 sel rw, count ro", q, 32'h0000_0A03);
      wr(2'd2, 32'hFFFF_FFA5);
      rd(2'd2, q); chk("R7 window fields", q, 32'h0000_00A5);
      wr(2'd1, 32'h0000_0004);
      rd(2'd2, q); chk("R7 other port untouched", q, 32'h0);
      // R11: read data is the value before the write of that access
      wr(2'd1, 32'h0000_0003);
      acc(1'b1, 2'd2, 32'h0000_005A, q);
      chk("R11 old value returned", q, 32'h0000_00A5);
      rd(2'd2, q); chk("R7 rewrite", q, 32'h0000_005A);
   endtask

   task automatic t_enable;
      logic [31:0] q;
      chk("R2 disabled zero", 32'(pcfg == '0), 32'd1);
      wr(2'd0, 32'h0010_2101);
      chk("R2 enabled port3", 32'(pcfg[3*8 +: 8]), 32'h5A);
      chk("R2 enabled port0", 32'(pcfg[0 +: 8]), 32'h00);
      wr(2'd0, 32'h0010_2100);
      chk("R2 disabled again", 32'(pcfg == '0), 32'd1);
      wr(2'd0, 32'h0010_2101);
   endtask

   task automatic t_poly;
      logic [31:0] q;
      wr(2'd0, 32'h0080_0501);
      chk("R5 accept 8005", 32'(poly), 32'h8005);
      wr(2'd0, 32'h0012_3401);
      chk("R5 reject 1234", 32'(poly), 32'h8005);
      wr(2'd0, 32'h0005_8901);
      rd(2'd0, q); chk("R5 accept 0589", q, 32'h0005_8901);
   endtask

   task automatic t_flush;
      logic [31:0] q;
      wr(2'd0, 32'h0005_8901);
      chk("R3 zero trigger no start", 32'(start | busy), 32'd0);
      @(negedge clk);
      cyc = 1'b1; we = 1'b1; addr = 2'd0; wdata = 32'h0005_8903;
      @(negedge clk);
      cyc = 1'b0; we = 1'b0;
      chk("R3 start pulse", 32'(start), 32'd1);
      chk("R3 busy set", 32'(busy), 32'd1);
      @(negedge clk);
      chk("R3 start single", 32'(start), 32'd0);
      rd(2'd0, q); chk("R3 busy readback", 32'(q[1]), 32'd1);
      // R4: trigger while busy is ignored
      @(negedge clk);
      cyc = 1'b1; we = 1'b1; addr = 2'd0; wdata = 32'h0005_8903;
      @(negedge clk);
      cyc = 1'b0; we = 1'b0;
      chk("R4 no start while busy", 32'(start), 32'd0);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk("R4 busy cleared by done", 32'(busy), 32'd0);
      rd(2'd0, q); chk("R4 idle readback", 32'(q[1]), 32'd0);
   endtask

   task automatic t_oob;
      logic [31:0] q;
      wr(2'd1, 32'h0000_000A);
      rd(2'd2, q); chk("R8 oob read zero", q, 32'h0);
      wr(2'd2, 32'h0000_00FF);
      rd(2'd2, q); chk("R8 oob read after write", q, 32'h0);
      chk("R8 no port changed", 32'(pcfg[9*8 +: 8]), 32'h0);
      chk("R8 port3 intact", 32'(pcfg[3*8 +: 8]), 32'h5A);
   endtask

   task automatic t_engine;
      logic [31:0] q;
      @(negedge clk);
      eld = 1'b1; eport = 8'd7; ecfg = 8'h3C;
      @(negedge clk);
      eld = 1'b0;
      chk("R9 engine load out", 32'(pcfg[7*8 +: 8]), 32'h3C);
      wr(2'd1, 32'h0000_0007);
      rd(2'd2, q); chk("R9 engine load window", q, 32'h3C);
   endtask

   task automatic t_collide;
      logic [31:0] q;
      // same port 7: bus wins
      @(negedge clk);
      cyc = 1'b1; we = 1'b1; addr = 2'd2; wdata = 32'h0000_0011;
      eld = 1'b1; eport = 8'd7; ecfg = 8'h22;
      @(negedge clk);
      cyc = 1'b0; we = 1'b0; eld = 1'b0;
      chk("R10 bus wins", 32'(pcfg[7*8 +: 8]), 32'h11);
      // different ports: both land
      @(negedge clk);
      cyc = 1'b1; we = 1'b1; addr = 2'd2; wdata = 32'h0000_0044;
      eld = 1'b1; eport = 8'd1; ecfg = 8'h81;
      @(negedge clk);
      cyc = 1'b0; we = 1'b0; eld = 1'b0;
      chk("R10 bus port7", 32'(pcfg[7*8 +: 8]), 32'h44);
      chk("R10 engine port1", 32'(pcfg[1*8 +: 8]), 32'h81);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ack();
      t_window();
      t_enable();
      t_poly();
      t_flush();
      t_oob();
      t_engine();
      t_collide();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule